// File: doc/BRIEF.md
# DMA Channel Scheduler with Loop Linking

This block decides which channel of a multi-channel DMA controller runs next and keeps each channel's loop bookkeeping. Channels ask for service through hardware request lines, which can be masked one by one, or through software start pulses. The block picks one winner, either by fixed priority or in round-robin order, and announces it with a one-cycle grant pulse. It then holds that channel active until the transfer engine reports that a minor loop is complete or that an error occurred.

Each channel has a major-iteration counter that counts down by one per completed minor loop. When the count runs out, the channel's done flag is set. A finished minor loop can start another channel through its minor link. A finished major loop can start another channel through its major link. A channel that links to itself in continuous mode restarts at once, without going back through arbitration. An error can freeze the scheduler until software clears the halt. While debug mode and the stall bit are both set, new channel starts are held off, but a channel that is already running is allowed to finish.

Top module: `dma_chan_sched`

## Requirements
- R1: With `mode_rr` low, a grant goes to the highest-numbered pending channel.
- R2: With `mode_rr` high, the search for a winner starts at the channel one above the last one granted and wraps from NCH-1 to 0.
- R3: A channel is pending when its START bit is set, or when its `hw_req` bit and its `hw_req_en` bit are both high. A `sw_start` pulse sets START at the next edge, so a grant can follow one edge later. START clears on the edge where the channel is granted.
- R4: At most one channel is active at a time. A grant is given only while no channel is active. A grant raises `busy` and `grant` for one cycle together with `active_ch`, one edge after the request is seen. `active_ch` does not change while the channel is busy. After reset, `busy`, `grant`, `halted` and `done` are all 0.
- R5: An `eng_err` pulse ends the active channel. If `mode_hoe` is high, the pulse also sets `halted`. While `halted` is set, no grant is given. A `halt_clr` pulse clears `halted`, and grants can resume at the following edge.
- R6: An `iter_load` pulse loads a channel's counter from its `iter_cfg` byte field and clears its done flag. Each minor completion decrements the counter. The completion that finds a count of 1 or 0 is the final one: it sets `done[ch]`, reloads the counter, and ends the channel.
- R7: On a non-final completion, if the channel's minor link is enabled, the START bit of its `minor_link_tgt` field is set and the channel goes idle.
- R8: On a final completion, if the major link is enabled, the START bit of the `major_link_tgt` target is set. The minor link is not applied on a final completion. When the minor link is disabled, a non-final completion starts no other channel.
- R9: With `mode_clm` low, a minor self-link sets the channel's own START bit. The channel then competes again in arbitration, so another pending channel with higher priority can win first.
- R10: With `mode_clm` high, a non-final completion whose minor link targets the channel itself keeps `busy` high and re-pulses `grant` on the same channel at that edge.
- R11: While `dbg_mode` and `mode_dbg_stall` are both high, no new grant is given, but the active channel still completes. Grants resume once either signal drops.
- R12: When `eng_err` and `eng_minor_done` arrive in the same cycle, the error wins. The counter is not decremented, no link fires, and the done flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | NCH | Hardware request per channel |
| hw_req_en | input | NCH | Enable for each hardware request |
| sw_start | input | NCH | Pulse that sets a channel's START bit |
| minor_link_en | input | NCH | Minor-loop link enable per channel |
| minor_link_tgt | input | NCH*CW | Minor-link target, field ch at bits [ch*CW +: CW] |
| major_link_en | input | NCH | Major-loop link enable per channel |
| major_link_tgt | input | NCH*CW | Major-link target, field ch at bits [ch*CW +: CW] |
| iter_cfg | input | NCH*ITERW | Major-iteration count, field ch at bits [ch*ITERW +: ITERW] |
| iter_load | input | NCH | Loads the counter and clears the done flag |
| mode_rr | input | 1 | Round-robin arbitration when high |
| mode_hoe | input | 1 | Halt on error when high |
| mode_clm | input | 1 | Continuous self-link when high |
| mode_dbg_stall | input | 1 | Stall new starts while in debug mode |
| dbg_mode | input | 1 | System debug state |
| halt_clr | input | 1 | Pulse that clears the halt flag |
| eng_minor_done | input | 1 | Engine reports the active channel's minor loop is complete |
| eng_err | input | 1 | Engine reports an error on the active channel |
| busy | output | 1 | A channel is active |
| active_ch | output | CW | Index of the active channel |
| grant | output | 1 | One-cycle pulse when a channel is started or restarted |
| halted | output | 1 | Scheduler halted after an error |
| done | output | NCH | Per-channel major-loop done flags |

## Verification
Two events can land on the same edge: an engine error and a minor-loop completion for the active channel. The bench drives both pulses in one cycle on a channel that has a minor link and a count of 2. It then expects the channel to go idle with its done flag still clear and its link target left idle. On the next normal completion of that channel, the count still reads 2: the result is non-final and the link fires. This shows that the collision did not consume an iteration.

// File: rtl/dma_sched_pkg.sv
// Package: shared types for the DMA channel scheduler.
// Assumes: channel indices fit in the CW width that the top module derives.
package dma_sched_pkg;

    // How the arbiter picks among pending channels
    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;

    // Outcome of one completion event, as decided by the link logic
    typedef struct packed {
        logic restart;   // continuous self-link, stay busy
        logic release_ch; // channel goes idle
    } cmpl_act_t;

endpackage

// File: rtl/dma_sched_arb.sv
// Module: combinational channel arbiter.
// Fixed mode returns the highest-numbered pending channel. Round mode
// searches upward from the channel after last_gnt and wraps around.
// Assumes: the caller registers the result; last_gnt is a valid index.
module dma_sched_arb #(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] pending,
    input  dma_sched_pkg::arb_mode_e mode,
    input  logic [CW-1:0]  last_gnt,
    output logic           any,
    output logic [CW-1:0]  win
);
    logic [CW-1:0] win_fix;
    logic [CW-1:0] win_rr;

    // Fixed priority: the last hit in ascending order is the highest index
    always_comb begin
        win_fix = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pending[i]) win_fix = CW'(i);
        end
    end

    // Round robin: the first hit at or after last_gnt+1, modulo NCH
    always_comb begin
        logic hit;
        int   idx;
        hit    = 1'b0;
        win_rr = '0;
        for (int k = 1; k <= NCH; k++) begin
            idx = (int'(last_gnt) + k) % NCH;
            if (!hit && pending[idx]) begin
                win_rr = CW'(idx);
                hit    = 1'b1;
            end
        end
    end

    // Output select
    always_comb begin
        any = |pending;
        win = (mode == dma_sched_pkg::ARB_ROUND) ? win_rr : win_fix;
    end
endmodule

// File: rtl/dma_sched_iter.sv
// Module: major-iteration counter for one channel.
// A load takes the configured count and clears done. A decrement on a
// count of 1 or 0 is final: it sets done and reloads the count.
// Assumes: load and dec do not occur together (load has priority).
module dma_sched_iter #(
    parameter int ITERW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ITERW-1:0] cfg,
    input  logic             dec,
    output logic             is_last,
    output logic             done
);
    logic [ITERW-1:0] cnt;

    // A count of 1 or 0 means the next completion is the final one
    always_comb is_last = (cnt <= ITERW'(1));

    // Counter and sticky done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (load) begin
            cnt  <= cfg;
            done <= 1'b0;
        end else if (dec) begin
            if (is_last) begin
                cnt  <= cfg;
                done <= 1'b1;
            end else begin
                cnt <= cnt - ITERW'(1);
            end
        end
    end
endmodule

// File: rtl/dma_sched_link.sv
// Module: decides what a completion event triggers.
// A final completion applies the major link. A non-final completion
// applies the minor link, or restarts the channel directly when the
// minor link targets the channel itself and continuous mode is on.
// Assumes: fin is asserted only for a valid completion of the active channel.
module dma_sched_link #(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [CW-1:0]     active,
    input  logic              fin,
    input  logic              is_final,
    input  logic [NCH-1:0]    minor_en,
    input  logic [NCH*CW-1:0] minor_tgt,
    input  logic [NCH-1:0]    major_en,
    input  logic [NCH*CW-1:0] major_tgt,
    input  logic              clm,
    output logic [NCH-1:0]    link_set,
    output dma_sched_pkg::cmpl_act_t act
);
    logic [CW-1:0] mn_t;
    logic [CW-1:0] mj_t;

    // Pick the active channel's link targets
    always_comb begin
        mn_t = minor_tgt[int'(active)*CW +: CW];
        mj_t = major_tgt[int'(active)*CW +: CW];
    end

    // Work out the link request and the channel outcome
    always_comb begin
        link_set       = '0;
        act.restart    = 1'b0;
        act.release_ch = 1'b0;
        if (fin) begin
            act.release_ch = 1'b1;
            if (is_final) begin
                if (major_en[active]) link_set[mj_t] = 1'b1;
            end else if (minor_en[active]) begin
                if (clm && (mn_t == active)) begin
                    act.restart    = 1'b1;
                    act.release_ch = 1'b0;
                end else begin
                    link_set[mn_t] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma_chan_sched.sv
// Module: top of the DMA channel scheduler.
// It holds the START bits, the active-channel state and the halt flag. It
// instantiates the arbiter, one iteration counter per channel, and the link logic.
// Assumes: the engine pulses eng_minor_done / eng_err only while busy,
// except that an error while idle still halts the block when mode_hoe is set.
module dma_chan_sched #(
    parameter int NCH   = 8,
    parameter int ITERW = 8,
    parameter int CW    = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       hw_req,
    input  logic [NCH-1:0]       hw_req_en,
    input  logic [NCH-1:0]       sw_start,
    input  logic [NCH-1:0]       minor_link_en,
    input  logic [NCH*CW-1:0]    minor_link_tgt,
    input  logic [NCH-1:0]       major_link_en,
    input  logic [NCH*CW-1:0]    major_link_tgt,
    input  logic [NCH*ITERW-1:0] iter_cfg,
    input  logic [NCH-1:0]       iter_load,
    input  logic                 mode_rr,
    input  logic                 mode_hoe,
    input  logic                 mode_clm,
    input  logic                 mode_dbg_stall,
    input  logic                 dbg_mode,
    input  logic                 halt_clr,
    input  logic                 eng_minor_done,
    input  logic                 eng_err,
    output logic                 busy,
    output logic [CW-1:0]        active_ch,
    output logic                 grant,
    output logic                 halted,
    output logic [NCH-1:0]       done
);
    import dma_sched_pkg::*;

    logic [NCH-1:0] start_q;
    logic [NCH-1:0] pending;
    logic [NCH-1:0] gnt_clr;
    logic [NCH-1:0] link_set;
    logic [NCH-1:0] is_last;
    logic [NCH-1:0] dec;
    logic [CW-1:0]  last_gnt;
    logic [CW-1:0]  win;
    logic           any;
    logic           stall;
    logic           grant_ok;
    logic           fin;
    arb_mode_e      amode;
    cmpl_act_t      act;

    // Request and gating terms
    always_comb begin
        pending  = start_q | (hw_req & hw_req_en);
        stall    = dbg_mode & mode_dbg_stall;
        amode    = mode_rr ? ARB_ROUND : ARB_FIXED;
        grant_ok = !busy && !halted && !stall && any;
        fin      = busy && eng_minor_done && !eng_err;
        gnt_clr  = '0;
        if (grant_ok) gnt_clr[win] = 1'b1;
    end

    dma_sched_arb #(.NCH(NCH), .CW(CW)) u_arb (
        .pending  (pending),
        .mode     (amode),
        .last_gnt (last_gnt),
        .any      (any),
        .win      (win)
    );

    // One major-iteration counter per channel
    for (genvar g = 0; g < NCH; g++) begin : g_iter
        always_comb dec[g] = fin && (active_ch == CW'(g));
        dma_sched_iter #(.ITERW(ITERW)) u_iter (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (iter_load[g]),
            .cfg     (iter_cfg[g*ITERW +: ITERW]),
            .dec     (dec[g]),
            .is_last (is_last[g]),
            .done    (done[g])
        );
    end

    dma_sched_link #(.NCH(NCH), .CW(CW)) u_link (
        .active    (active_ch),
        .fin       (fin),
        .is_final  (is_last[active_ch]),
        .minor_en  (minor_link_en),
        .minor_tgt (minor_link_tgt),
        .major_en  (major_link_en),
        .major_tgt (major_link_tgt),
        .clm       (mode_clm),
        .link_set  (link_set),
        .act       (act)
    );

    // START bits: set by software or links, cleared on grant
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= (start_q & ~gnt_clr) | sw_start | link_set;
    end

    // Active-channel state and grant pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            active_ch <= '0;
            grant     <= 1'b0;
            last_gnt  <= CW'(NCH - 1);
        end else begin
            grant <= 1'b0;
            if (busy && eng_err) begin
                busy <= 1'b0;
            end else if (fin) begin
                busy  <= act.restart;
                grant <= act.restart;
            end else if (grant_ok) begin
                busy      <= 1'b1;
                grant     <= 1'b1;
                active_ch <= win;
                last_gnt  <= win;
            end
        end
    end

    // Halt flag: an error sets it when enabled, software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                   halted <= 1'b0;
        else if (eng_err && mode_hoe) halted <= 1'b1;
        else if (halt_clr)            halted <= 1'b0;
    end
endmodule

// File: rtl/dma_sched_chk.sv
// Module: assertion checker for dma_chan_sched, attached with bind.
// Assumes: observes only the top module's ports.
module dma_sched_chk #(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           grant,
    input logic           halted,
    input logic [CW-1:0]  active_ch,
    input logic [NCH-1:0] done,
    input logic           eng_err,
    input logic           eng_minor_done,
    input logic           mode_hoe,
    input logic           dbg_mode,
    input logic           mode_dbg_stall
);
    AST_GRANT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy); // R4
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !grant) |-> $stable(active_ch)); // R4
    AST_HALT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !grant); // R5
    AST_ERR_SETS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_err && mode_hoe) |=> halted); // R5
    AST_STALL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && mode_dbg_stall && !busy) |=> !grant); // R11
    AST_ERR_ENDS_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_err) |=> (!busy && !grant)); // R12
    AST_DONE_FROM_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done & ~$past(done))) |-> $past(busy && eng_minor_done && !eng_err)); // R6
endmodule

bind dma_chan_sched dma_sched_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .grant          (grant),
    .halted         (halted),
    .active_ch      (active_ch),
    .done           (done),
    .eng_err        (eng_err),
    .eng_minor_done (eng_minor_done),
    .mode_hoe       (mode_hoe),
    .dbg_mode       (dbg_mode),
    .mode_dbg_stall (mode_dbg_stall)
);

// File: tb/test_dma_chan_sched.sv
module test_dma_chan_sched;
    localparam int NCH = 8;
    localparam int ITERW = 8;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] hw_req = '0, hw_req_en = '1, sw_start = '0;
    logic [NCH-1:0] minor_link_en = '0, major_link_en = '0, iter_load = '0;
    logic [NCH*CW-1:0] minor_link_tgt = '0, major_link_tgt = '0;
    logic [NCH*ITERW-1:0] iter_cfg = '0;
    logic mode_rr = 0, mode_hoe = 0, mode_clm = 0, mode_dbg_stall = 0, dbg_mode = 0;
    logic halt_clr = 0, eng_minor_done = 0, eng_err = 0;
    logic busy, grant, halted;
    logic [CW-1:0] active_ch;
    logic [NCH-1:0] done;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_chan_sched #(.NCH(NCH), .ITERW(ITERW)) i_dma_chan_sched (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_req_en(hw_req_en),
        .sw_start(sw_start), .minor_link_en(minor_link_en),
        .minor_link_tgt(minor_link_tgt), .major_link_en(major_link_en),
        .major_link_tgt(major_link_tgt), .iter_cfg(iter_cfg), .iter_load(iter_load),
        .mode_rr(mode_rr), .mode_hoe(mode_hoe), .mode_clm(mode_clm),
        .mode_dbg_stall(mode_dbg_stall), .dbg_mode(dbg_mode), .halt_clr(halt_clr),
        .eng_minor_done(eng_minor_done), .eng_err(eng_err), .busy(busy),
        .active_ch(active_ch), .grant(grant), .halted(halted), .done(done));

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_ch();
        eng_minor_done = 1; step(); eng_minor_done = 0;
    endtask

    task automatic load_cnt(input int ch, input int val);
        iter_cfg[ch*ITERW +: ITERW] = ITERW'(val);
        iter_load[ch] = 1; step(); iter_load = '0;
    endtask

    task automatic clear_all();
        hw_req = '0; sw_start = '0; minor_link_en = '0; major_link_en = '0;
        iter_cfg = '0; iter_load = '1; step(); iter_load = '0; step();
    endtask

    task automatic t_reset();
        chk("R4 reset busy", busy, 0);
        chk("R4 reset grant", grant, 0);
        chk("R5 reset halted", halted, 0);
        chk("R6 reset done", done, 0);
    endtask

    task automatic t_fixed();
        hw_req = 8'b0010_0110; step();
        chk("R1 highest wins", active_ch, 5);
        chk("R4 grant pulse", grant, 1);
        hw_req = 8'b1000_0110; step();
        chk("R4 no preempt", active_ch, 5);
        chk("R4 grant one cycle", grant, 0);
        finish_ch();
        chk("R6 single-count done", done[5], 1);
        step();
        chk("R1 next highest", active_ch, 7);
        hw_req = '0; finish_ch(); step();
        chk("R4 idle", busy, 0);
        clear_all();
    endtask

    task automatic t_start();
        hw_req_en[6] = 0; hw_req[6] = 1;
        sw_start[3] = 1; step(); sw_start = '0;
        chk("R3 start latency", busy, 0);
        step();
        chk("R3 start grant", active_ch, 3);
        chk("R3 start busy", busy, 1);
        finish_ch(); step();
        chk("R3 start cleared, masked req ignored", busy, 0);
        hw_req = '0; hw_req_en = '1;
        clear_all();
    endtask

    task automatic t_rr();
        mode_rr = 1;
        hw_req = 8'b0000_0100; step();
        chk("R2 first", active_ch, 2);
        hw_req = 8'b1000_0101; finish_ch(); step();
        chk("R2 after 2", active_ch, 7);
        hw_req = 8'b0000_0101; finish_ch(); step();
        chk("R2 wrap", active_ch, 0);
        hw_req = 8'b0000_0100; finish_ch(); step();
        chk("R2 after 0", active_ch, 2);
        hw_req = '0; finish_ch(); step();
        mode_rr = 0;
        clear_all();
    endtask

    task automatic t_iter();
        load_cnt(1, 3);
        chk("R6 load clears done", done[1], 0);
        hw_req[1] = 1; step();
        finish_ch();
        chk("R6 after 1", done[1], 0);
        step(); finish_ch();
        chk("R6 after 2", done[1], 0);
        step(); hw_req = '0; finish_ch();
        chk("R6 after 3", done[1], 1);
        chk("R6 channel ends", busy, 0);
        clear_all();
    endtask

    task automatic t_minor();
        load_cnt(2, 2);
        minor_link_en[2] = 1; minor_link_tgt[2*CW +: CW] = 3'd6;
        hw_req[2] = 1; step(); hw_req = '0;
        finish_ch(); step();
        chk("R7 minor link starts target", active_ch, 6);
        chk("R7 target busy", busy, 1);
        finish_ch();
        hw_req[2] = 1; step(); hw_req = '0;
        finish_ch(); step();
        chk("R8 minor link not used on final", busy, 0);
        clear_all();
    endtask

    task automatic t_major();
        load_cnt(4, 2);
        major_link_en[4] = 1; major_link_tgt[4*CW +: CW] = 3'd1;
        hw_req[4] = 1; step(); hw_req = '0;
        finish_ch(); step();
        chk("R8 no link on minor when minor off", busy, 0);
        hw_req[4] = 1; step(); hw_req = '0;
        finish_ch(); step();
        chk("R8 major link target", active_ch, 1);
        chk("R8 major link busy", busy, 1);
        finish_ch();
        clear_all();
    endtask

    task automatic t_self_arb();
        load_cnt(3, 2);
        minor_link_en[3] = 1; minor_link_tgt[3*CW +: CW] = 3'd3;
        hw_req[3] = 1; step(); hw_req = 8'b0010_0000;
        finish_ch();
        chk("R9 goes idle", busy, 0);
        step();
        chk("R9 higher priority wins", active_ch, 5);
        hw_req = '0; finish_ch(); step();
        chk("R9 self link rearbitrated", active_ch, 3);
        finish_ch();
        clear_all();
    endtask

    task automatic t_clm();
        mode_clm = 1;
        load_cnt(3, 3);
        minor_link_en[3] = 1; minor_link_tgt[3*CW +: CW] = 3'd3;
        hw_req[3] = 1; step(); hw_req = 8'b0100_0000;
        finish_ch();
        chk("R10 stays busy", busy, 1);
        chk("R10 regrant pulse", grant, 1);
        chk("R10 same channel", active_ch, 3);
        finish_ch();
        chk("R10 second restart", grant, 1);
        finish_ch();
        chk("R10 final ends", busy, 0);
        step();
        chk("R10 other channel next", active_ch, 6);
        hw_req = '0; finish_ch();
        mode_clm = 0;
        clear_all();
    endtask

    task automatic t_halt();
        mode_hoe = 1;
        hw_req[2] = 1; step();
        eng_err = 1; step(); eng_err = 0;
        chk("R5 error ends", busy, 0);
        chk("R5 halted", halted, 1);
        step(); step();
        chk("R5 requests ignored", busy, 0);
        halt_clr = 1; step(); halt_clr = 0;
        chk("R5 halt cleared", halted, 0);
        step();
        chk("R5 resumes", busy, 1);
        eng_err = 1; mode_hoe = 0; step(); eng_err = 0;
        chk("R5 no halt when disabled", halted, 0);
        chk("R5 error ends w/o halt", busy, 0);
        hw_req = '0; step();
        clear_all();
    endtask

    task automatic t_dbg();
        hw_req[1] = 1; step(); hw_req = '0;
        dbg_mode = 1; mode_dbg_stall = 1; hw_req[4] = 1;
        finish_ch();
        chk("R11 active completes", busy, 0);
        step(); step();
        chk("R11 stalled", busy, 0);
        dbg_mode = 0; step();
        chk("R11 resume on debug exit", active_ch, 4);
        finish_ch();
        dbg_mode = 1; step();
        chk("R11 stalled again", busy, 0);
        mode_dbg_stall = 0; step();
        chk("R11 resume on stall clear", busy, 1);
        hw_req = '0; finish_ch();
        dbg_mode = 0;
        clear_all();
    endtask

    task automatic t_collide();
        load_cnt(5, 2);
        minor_link_en[5] = 1; minor_link_tgt[5*CW +: CW] = 3'd0;
        hw_req[5] = 1; step(); hw_req = '0;
        eng_err = 1; eng_minor_done = 1; step(); eng_err = 0; eng_minor_done = 0;
        chk("R12 collision ends", busy, 0);
        chk("R12 no done", done[5], 0);
        step();
        chk("R12 no link", busy, 0);
        hw_req[5] = 1; step(); hw_req = '0;
        finish_ch();
        chk("R12 count not consumed", done[5], 0);
        step();
        chk("R12 link after clean completion", active_ch, 0);
        finish_ch();
        clear_all();
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1; step();
        t_fixed();
        t_start();
        t_rr();
        t_iter();
        t_minor();
        t_major();
        t_self_arb();
        t_clm();
        t_halt();
        t_dbg();
        t_collide();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule